// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Register Bank

This block keeps one 32-bit control and status word for each channel of a multi-channel DMA controller and turns the flags in those words into interrupt information. The CPU side writes one channel's word at a time. Within that word, some flags are cleared by writing a one, some bits are plain control settings, a pair of strobe bits sets or clears a compare flag, and the run and mask-run bits decide the stop flag. The channel engines raise flags with one-cycle event pulses. A hardware event always wins over a CPU clear that lands in the same cycle.

The block gives back three things. The first is the selected channel's word; in it, bit 8 is replaced by the live level of that channel's request line. The second is a global interrupt word with one bit per channel. The third is a single interrupt line. The start and end flags raise an interrupt on their own. The stop, end-of-receive and request-after-stop flags raise one only when their enable bits are set. The bus-error flag is held for software to read but never raises an interrupt. The channel count is a parameter from 2 to 32.

Top module: `dma_csr_irq`

## Requirements
- R1: After reset, every channel word reads 0x0000_0008 (only the stop flag, bit 3, is set), the interrupt word is zero and the interrupt line is low.
- R2: Writing a one to bit 0 (bus error), bit 1 (start), bit 2 (end) or bit 9 (end-of-receive) clears that flag. Writing a zero there leaves the flag as it was.
- R3: Bits 31:26 and bit 23 take the written value. Bits 5-7, 11-22, 24 and 25 always read zero. Bits 4 and 10 are changed by no write except through their own rules.
- R4: A write with bit 24 set clears the compare flag (bit 10). A write with bit 25 set sets it. When both are set in one write, the flag ends up set.
- R5: A write with run (bit 31) set clears the stop flag. A write with both run and mask-run (bit 22) clear sets the stop flag. A write with mask-run set and run clear leaves the stop flag unchanged.
- R6: When a channel word is read, bit 8 shows the current level of that channel's request input. The level is not stored.
- R7: A channel's interrupt-word bit is raised by: the stop flag when bit 29 is set, the end-of-receive flag when bit 28 is set, or the request-after-stop flag (bit 4) when bit 23 is set. With the enable clear, that flag alone raises nothing.
- R8: The start and end flags raise the channel's interrupt-word bit with no enable. The bus-error flag never raises it.
- R9: The interrupt line is high exactly when the interrupt word is nonzero. Both follow a register change in the next cycle.
- R10: An event pulse that sets a flag in the same cycle as a CPU write clearing it leaves the flag set.
- R11: A write to one channel changes no other channel's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | CPU write strobe, one cycle |
| wr_chan | input | CW | Channel addressed by the write |
| wr_data | input | 32 | Write value |
| rd_chan | input | CW | Channel whose word appears on rd_data |
| rd_data | output | 32 | Selected channel word, request level in bit 8 |
| req_lvl | input | NCH | Live request level per channel |
| ev_buserr | input | NCH | Bus-error event pulses |
| ev_start | input | NCH | Descriptor-start event pulses |
| ev_end | input | NCH | Transfer-end event pulses |
| ev_eor | input | NCH | End-of-receive event pulses |
| ev_ras | input | NCH | Request-after-stop event pulses |
| ev_stop | input | NCH | Channel-stopped event pulses |
| irq_word | output | NCH | Per-channel interrupt status |
| irq_out | output | 1 | Combined interrupt line |

## Verification
Each flag is raised both with its enable clear and with its enable set. This shows which flags are gated and which are not. The write tests use all-ones values, strobe-only values and mask-run-only values. Together these separate stored control bits, bits that are dropped, clear-on-one behaviour and the three stop-flag outcomes. One event is made to coincide with a clear of the same flag, which shows whether the event wins. Each check also reads a channel that was not written, to confirm that it stayed unchanged.

// File: rtl/dma_csr_pkg.sv
// Shared bit positions, masks and the event bundle for the DMA
// channel status register bank.
package dma_csr_pkg;
    localparam int B_BUSERR  = 0;
    localparam int B_START   = 1;
    localparam int B_END     = 2;
    localparam int B_STOP    = 3;
    localparam int B_RAS     = 4;
    localparam int B_REQ     = 8;
    localparam int B_EOR     = 9;
    localparam int B_CMP     = 10;
    localparam int B_MASKRUN = 22;
    localparam int B_RASEN   = 23;
    localparam int B_CMPCLR  = 24;
    localparam int B_CMPSET  = 25;
    localparam int B_EOREN   = 28;
    localparam int B_STOPEN  = 29;
    localparam int B_RUN     = 31;

    // Status bits held across a write (bit 8 is live, never stored)
    localparam logic [31:0] KEEP_MASK = 32'h0000_061F;
    // Control bits loaded straight from the write value
    localparam logic [31:0] CTRL_MASK = 32'hFC80_0000;
    // Flags cleared by writing one
    localparam logic [31:0] W1C_MASK  = 32'h0000_0207;
    localparam logic [31:0] RST_WORD  = 32'h0000_0008;

    typedef struct packed {
        logic buserr;
        logic start;
        logic fin;
        logic eor;
        logic ras;
        logic stop;
    } chan_ev_t;
endpackage

// File: rtl/dma_csr_chan.sv
// One channel's control/status word.
// Assumes: wr_hit is a single-cycle strobe; event pulses are one cycle.
// Event pulses are applied after the CPU write, so an event beats a clear.
module dma_csr_chan
    import dma_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  logic [31:0] wr_data,
    input  chan_ev_t    ev,
    output logic [31:0] stat_q
);
    logic [31:0] nxt;

    // Next word: CPU write rules first, then hardware events on top
    always_comb begin
        nxt = stat_q;
        if (wr_hit) begin
            nxt = (stat_q & KEEP_MASK & ~(wr_data & W1C_MASK))
                | (wr_data & CTRL_MASK);
            if (wr_data[B_RUN]) begin
                nxt[B_STOP] = 1'b0;
            end else if (!wr_data[B_MASKRUN]) begin
                nxt[B_STOP] = 1'b1;
            end
            if (wr_data[B_CMPCLR]) nxt[B_CMP] = 1'b0;
            if (wr_data[B_CMPSET]) nxt[B_CMP] = 1'b1;
        end
        if (ev.buserr) nxt[B_BUSERR] = 1'b1;
        if (ev.start)  nxt[B_START]  = 1'b1;
        if (ev.fin)    nxt[B_END]    = 1'b1;
        if (ev.eor)    nxt[B_EOR]    = 1'b1;
        if (ev.ras)    nxt[B_RAS]    = 1'b1;
        if (ev.stop)   nxt[B_STOP]   = 1'b1;
    end

    // Word register with reset to stop-only
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= RST_WORD;
        else        stat_q <= nxt;
    end
endmodule

// File: rtl/dma_csr_irq_merge.sv
// Builds the five per-channel interrupt bitmaps from the channel words
// and reduces them to the global interrupt word and the single line.
// Assumes: channel words come straight from registers (output is one
// gate level deep from state).
module dma_csr_irq_merge
    import dma_csr_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0][31:0] stat,
    output logic [NCH-1:0]       irq_word,
    output logic                 irq_out
);
    logic [NCH-1:0] map_stop, map_eor, map_ras, map_start, map_end;

    for (genvar g = 0; g < NCH; g++) begin : g_map
        // Gated and ungated sources for channel g
        always_comb begin
            map_stop[g]  = stat[g][B_STOP] & stat[g][B_STOPEN];
            map_eor[g]   = stat[g][B_EOR]  & stat[g][B_EOREN];
            map_ras[g]   = stat[g][B_RAS]  & stat[g][B_RASEN];
            map_start[g] = stat[g][B_START];
            map_end[g]   = stat[g][B_END];
        end
    end

    // Global word and combined line
    always_comb begin
        irq_word = map_stop | map_eor | map_ras | map_start | map_end;
        irq_out  = |irq_word;
    end
endmodule

// File: rtl/dma_csr_rdmux.sv
// Read-back selector: returns the addressed channel word with the live
// request level inserted at bit 8. Assumes rd_chan below NCH; other
// values read zero.
module dma_csr_rdmux
    import dma_csr_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 3
) (
    input  logic [NCH-1:0][31:0] stat,
    input  logic [NCH-1:0]       req_lvl,
    input  logic [CW-1:0]        rd_chan,
    output logic [31:0]          rd_data
);
    // Select and overlay the request level
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (int'(rd_chan) == i) begin
                rd_data = stat[i];
                rd_data[B_REQ] = req_lvl[i];
            end
        end
    end
endmodule

// File: rtl/dma_csr_irq.sv
// Top of the DMA channel status register bank. Decodes CPU writes to
// channels, bundles engine events per channel, and exposes read-back
// and interrupt outputs. Assumes NCH between 2 and 32, synchronous
// active-low reset.
module dma_csr_irq
    import dma_csr_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CW-1:0]  wr_chan,
    input  logic [31:0]    wr_data,
    input  logic [CW-1:0]  rd_chan,
    output logic [31:0]    rd_data,
    input  logic [NCH-1:0] req_lvl,
    input  logic [NCH-1:0] ev_buserr,
    input  logic [NCH-1:0] ev_start,
    input  logic [NCH-1:0] ev_end,
    input  logic [NCH-1:0] ev_eor,
    input  logic [NCH-1:0] ev_ras,
    input  logic [NCH-1:0] ev_stop,
    output logic [NCH-1:0] irq_word,
    output logic           irq_out
);
    logic [NCH-1:0][31:0] chan_stat;
    logic [NCH-1:0]       wr_hit;
    chan_ev_t             ev_c [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Write decode and event bundling for channel g
        always_comb begin
            wr_hit[g]      = wr_en && (int'(wr_chan) == g);
            ev_c[g].buserr = ev_buserr[g];
            ev_c[g].start  = ev_start[g];
            ev_c[g].fin    = ev_end[g];
            ev_c[g].eor    = ev_eor[g];
            ev_c[g].ras    = ev_ras[g];
            ev_c[g].stop   = ev_stop[g];
        end

        dma_csr_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit[g]),
            .wr_data (wr_data),
            .ev      (ev_c[g]),
            .stat_q  (chan_stat[g])
        );
    end

    dma_csr_irq_merge #(.NCH(NCH)) u_merge (
        .stat     (chan_stat),
        .irq_word (irq_word),
        .irq_out  (irq_out)
    );

    dma_csr_rdmux #(.NCH(NCH), .CW(CW)) u_rd (
        .stat    (chan_stat),
        .req_lvl (req_lvl),
        .rd_chan (rd_chan),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/dma_csr_irq_chk.sv
// Assertion checker for dma_csr_irq, attached by bind below.
module dma_csr_irq_chk
    import dma_csr_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [CW-1:0]        wr_chan,
    input logic [31:0]          wr_data,
    input logic [NCH-1:0]       ev_start,
    input logic [NCH-1:0]       ev_end,
    input logic [NCH-1:0]       ev_stop,
    input logic [NCH-1:0]       irq_word,
    input logic                 irq_out,
    input logic [NCH-1:0][31:0] chan_stat
);
    localparam logic [31:0] ZERO_MASK = ~(KEEP_MASK | CTRL_MASK);

    // R5: run write clears the stop flag when no stop event coincides
    a_r5_run_clears_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_RUN] && ev_stop == '0)
        |=> !chan_stat[$past(wr_chan)][B_STOP]);

    // R4: set strobe leaves compare flag set
    a_r4_cmp_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_CMPSET]) |=> chan_stat[$past(wr_chan)][B_CMP]);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R3: unstored bits stay zero
        a_r3_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_stat[g] & ZERO_MASK) == 32'h0);
        // R10: end event sets the flag whatever the CPU writes; line rises
        a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ev_end[g] |=> (chan_stat[g][B_END] && irq_out));
        // R8: start event raises the channel's interrupt bit next cycle
        a_r8_start_irq: assert property (@(posedge clk) disable iff (!rst_n)
            ev_start[g] |=> irq_word[g]);
    end
endmodule

bind dma_csr_irq dma_csr_irq_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_chan   (wr_chan),
    .wr_data   (wr_data),
    .ev_start  (ev_start),
    .ev_end    (ev_end),
    .ev_stop   (ev_stop),
    .irq_word  (irq_word),
    .irq_out   (irq_out),
    .chan_stat (chan_stat)
);

// File: tb/sim_dma_csr_irq.sv
// Scoreboard bench: driver pushes expected read-backs, monitor compares.
module sim_dma_csr_irq;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int CW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [CW-1:0]  wr_chan = '0;
    logic [31:0]    wr_data = '0;
    logic [CW-1:0]  rd_chan = '0;
    logic [31:0]    rd_data;
    logic [NCH-1:0] req_lvl = '0;
    logic [NCH-1:0] ev_buserr = '0, ev_start = '0, ev_end = '0;
    logic [NCH-1:0] ev_eor = '0, ev_ras = '0, ev_stop = '0;
    logic [NCH-1:0] irq_word;
    logic           irq_out;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;

    typedef struct {
        int             ch;
        logic [31:0]    rd;
        logic [NCH-1:0] word;
        string          tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_csr_irq #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_data(wr_data), .rd_chan(rd_chan), .rd_data(rd_data),
        .req_lvl(req_lvl), .ev_buserr(ev_buserr), .ev_start(ev_start),
        .ev_end(ev_end), .ev_eor(ev_eor), .ev_ras(ev_ras),
        .ev_stop(ev_stop), .irq_word(irq_word), .irq_out(irq_out)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: pops one expectation per falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                rd_chan = CW'(it.ch);
                #1;
                checks++;
                if (rd_data !== it.rd) begin
                    errors++;
                    $display("FAIL %s ch%0d rd_data actual=%h expected=%h", it.tag, it.ch, rd_data, it.rd);
                end
                checks++;
                if (irq_word !== it.word) begin
                    errors++;
                    $display("FAIL %s irq_word actual=%h expected=%h", it.tag, irq_word, it.word);
                end
                checks++;
                if (irq_out !== (it.word != '0)) begin
                    errors++;
                    $display("FAIL %s irq_out actual=%b expected=%b", it.tag, irq_out, it.word != '0);
                end
                done_cnt++;
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    task automatic expect_rd(int ch, logic [31:0] rd, logic [NCH-1:0] word, string tag);
        exp_t it;
        int target;
        it.ch = ch; it.rd = rd; it.word = word; it.tag = tag;
        target = done_cnt + 1;
        sb.push_back(it);
        wait (done_cnt >= target);
    endtask

    task automatic cpu_wr(int ch, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = CW'(ch); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Write with a start event on the same channel in the same cycle
    task automatic cpu_wr_start(int ch, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = CW'(ch); wr_data = d;
        ev_start[ch] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ev_start = '0;
    endtask

    // kind: 0 buserr, 1 start, 2 end, 3 eor, 4 ras, 5 stop
    task automatic pulse(int ch, int kind);
        @(negedge clk);
        case (kind)
            0: ev_buserr[ch] = 1'b1;
            1: ev_start[ch]  = 1'b1;
            2: ev_end[ch]    = 1'b1;
            3: ev_eor[ch]    = 1'b1;
            4: ev_ras[ch]    = 1'b1;
            default: ev_stop[ch] = 1'b1;
        endcase
        @(negedge clk);
        ev_buserr = '0; ev_start = '0; ev_end = '0;
        ev_eor = '0; ev_ras = '0; ev_stop = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        expect_rd(0, 32'h0000_0008, 8'h00, "R1 reset ch0");
        expect_rd(7, 32'h0000_0008, 8'h00, "R1 reset ch7");

        req_lvl[2] = 1'b1;
        expect_rd(2, 32'h0000_0108, 8'h00, "R6 request high");
        req_lvl[2] = 1'b0;
        expect_rd(2, 32'h0000_0008, 8'h00, "R6 request low");

        cpu_wr(1, 32'hFFFF_FFFF);
        expect_rd(1, 32'hFC80_0400, 8'h00, "R3 R4 all-ones write");
        expect_rd(0, 32'h0000_0008, 8'h00, "R11 neighbour untouched");

        cpu_wr(1, 32'h0100_0000);
        expect_rd(1, 32'h0000_0008, 8'h00, "R4 R5 cmp clear and stop set");

        cpu_wr(1, 32'h8000_0000);
        expect_rd(1, 32'h8000_0000, 8'h00, "R5 run clears stop");
        cpu_wr(1, 32'h0040_0000);
        expect_rd(1, 32'h0000_0000, 8'h00, "R5 mask-run keeps stop clear");
        cpu_wr(1, 32'h0000_0000);
        expect_rd(1, 32'h0000_0008, 8'h00, "R5 zero write sets stop");

        cpu_wr(3, 32'h2000_0000);
        expect_rd(3, 32'h2000_0008, 8'h08, "R7 R9 stop enabled");
        cpu_wr(3, 32'h0000_0000);
        expect_rd(3, 32'h0000_0008, 8'h00, "R7 stop gated off");

        pulse(4, 1);
        expect_rd(4, 32'h0000_000A, 8'h10, "R8 start ungated");
        cpu_wr(4, 32'h0040_0002);
        expect_rd(4, 32'h0000_0008, 8'h00, "R2 start cleared");

        pulse(5, 2);
        expect_rd(5, 32'h0000_000C, 8'h20, "R8 end ungated");
        cpu_wr(5, 32'h0040_0000);
        expect_rd(5, 32'h0000_000C, 8'h20, "R2 zero leaves end");
        cpu_wr(5, 32'h0040_0004);
        expect_rd(5, 32'h0000_0008, 8'h00, "R2 end cleared");

        pulse(6, 3);
        expect_rd(6, 32'h0000_0208, 8'h00, "R7 eor without enable");
        cpu_wr(6, 32'h1040_0000);
        expect_rd(6, 32'h1000_0208, 8'h40, "R7 eor enabled");
        cpu_wr(6, 32'h1040_0200);
        expect_rd(6, 32'h1000_0008, 8'h00, "R2 eor cleared");

        pulse(7, 4);
        expect_rd(7, 32'h0000_0018, 8'h00, "R7 ras without enable");
        cpu_wr(7, 32'h0080_0000);
        expect_rd(7, 32'h0080_0018, 8'h80, "R7 ras enabled");
        cpu_wr(7, 32'h0000_0000);
        expect_rd(7, 32'h0000_0018, 8'h00, "R3 ras survives write");

        pulse(4, 1);
        cpu_wr_start(4, 32'h0040_0002);
        expect_rd(4, 32'h0000_000A, 8'h10, "R10 event beats clear");
        cpu_wr(4, 32'h0040_0002);
        expect_rd(4, 32'h0000_0008, 8'h00, "R10 later clear");

        pulse(0, 0);
        expect_rd(0, 32'h0000_0009, 8'h00, "R8 bus error no irq");
        cpu_wr(0, 32'h0040_0001);
        expect_rd(0, 32'h0000_0008, 8'h00, "R2 bus error cleared");

        cpu_wr(1, 32'hA000_0000);
        expect_rd(1, 32'hA000_0000, 8'h00, "R5 run with stop enable");
        pulse(1, 5);
        expect_rd(1, 32'hA000_0008, 8'h02, "R7 R9 stop event irq");
        cpu_wr(1, 32'h0000_0000);
        expect_rd(1, 32'h0000_0008, 8'h00, "R9 irq dropped");

        finish_run();
    end
endmodule